// File: doc/BRIEF.md
# Burst-Gated PWM Pulse Generator

This block drives a single output with bursts of fixed-frequency pulses. A free-running up-counter defines a short period, and a duty compare sets the width of the high phase in each short period. A second counter tracks short periods within a longer frame. The first few short periods of each frame carry pulses, and the output is held low for the rest of the frame. The pattern then repeats.

A clock divider ahead of the counter sets the tick rate to the input clock divided by 1, 2, 4 or 8. Configuration is captured into shadow registers while the block is disabled, and again at each frame boundary. Changes made during a frame therefore never cut a pulse short. A one-clock strobe marks the start of every short period that follows a completed one, so downstream logic can follow the pattern.

Top module: `burst_pwm_gen`

## Requirements
- R1: The tick counter runs from 0 up to the period value and then returns to 0, so each short period lasts period+1 ticks.
- R2: Within a pulsing short period, the output is high while the counter is below the duty value and low otherwise. A duty of 0 keeps the output low. Any duty above the period value keeps it high for the whole short period.
- R3: A frame consists of long_len short periods, and a long_len of 0 counts as 1. Short periods 0 to burst_len-1 of each frame pulse, and the remaining short periods are forced low. A burst_len of 0 gives a constant low output, and a burst_len of long_len or more gives continuous PWM.
- R4: The divider select takes the values 0, 1, 2 and 3. These make one tick every 1, 2, 4 and 8 clocks respectively.
- R5: All configuration inputs are captured while the block is disabled and at the clock edge that ends a frame, and at no other time. A change made mid-frame takes effect at the next frame.
- R6: When en_i is low at a clock edge, the output is low after that edge and both counters are cleared. After en_i returns high, the first clock edge starts a new frame at count 0. The output is then high from that edge on, provided duty and burst_len are nonzero.
- R7: cycle_end_o is high for the one clock in which the counter has just returned to 0 from the period value. It does not pulse when a frame is started by enabling.
- R8: After reset, pwm_o and cycle_end_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| div_sel_i | input | 2 | Tick divider select: 0=/1, 1=/2, 2=/4, 3=/8 |
| period_i | input | CNT_W | Short period minus one, in ticks |
| duty_i | input | CNT_W | High time of each pulse, in ticks |
| burst_len_i | input | CYC_W | Pulsing short periods per frame |
| long_len_i | input | CYC_W | Short periods per frame |
| pwm_o | output | 1 | Pulse output |
| cycle_end_o | output | 1 | Strobe at the start of each following short period |

## Verification
The hardest case to reach is a configuration change in the middle of a frame. It must leave the running frame untouched and then take over cleanly at the boundary, even when the change alters the divider ratio. The bench drives a new period, duty, burst length and divider a few clocks after enabling. It then compares every clock against a waveform computed from elapsed time, using the old setting up to the frame length and the new one after it. A second hard case is a disable that arrives while a pulse is high. The bench drops enable at exactly that point and checks that the output is low on the next clock and that a clean restart follows.

// File: rtl/burst_pwm_pkg.sv
package burst_pwm_pkg;

  typedef enum logic [1:0] {
    DIV_1 = 2'd0,
    DIV_2 = 2'd1,
    DIV_4 = 2'd2,
    DIV_8 = 2'd3
  } div_sel_e;

  localparam int unsigned DIV_W = 3;

  function automatic logic [DIV_W-1:0] div_mask(div_sel_e sel);
    logic [DIV_W-1:0] m;
    m = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/burst_pwm_prescaler.sv
module burst_pwm_prescaler
  import burst_pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     adv_i,
  input  logic     clr_i,
  input  div_sel_e sel_i,
  output logic     tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = div_mask(sel_i);
  assign tick_o = adv_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!adv_i || clr_i)   div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/burst_pwm_timer.sv
module burst_pwm_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = adv_i && tick_i && (cnt_q >= period_i);

  always_comb begin
    if (!adv_i)       cnt_nxt_o = '0;
    else if (wrap_o)  cnt_nxt_o = '0;
    else if (tick_i)  cnt_nxt_o = cnt_q + 1'b1;
    else              cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/burst_pwm_cycler.sv
module burst_pwm_cycler #(
  parameter int unsigned CYC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             wrap_i,
  input  logic [CYC_W-1:0] long_len_i,
  output logic [CYC_W-1:0] cyc_o,
  output logic [CYC_W-1:0] cyc_nxt_o,
  output logic             long_end_o
);

  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W:0]   cyc_inc;
  logic             last;

  assign cyc_inc    = {1'b0, cyc_q} + 1'b1;
  // long_len of 0 behaves as 1
  assign last       = cyc_inc >= {1'b0, long_len_i};
  assign long_end_o = wrap_i && last;

  always_comb begin
    if (!adv_i)          cyc_nxt_o = '0;
    else if (long_end_o) cyc_nxt_o = '0;
    else if (wrap_i)     cyc_nxt_o = cyc_inc[CYC_W-1:0];
    else                 cyc_nxt_o = cyc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_nxt_o;
  end

  assign cyc_o = cyc_q;

endmodule

// File: rtl/burst_pwm_gen.sv
module burst_pwm_gen
  import burst_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CYC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       div_sel_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CYC_W-1:0] burst_len_i,
  input  logic [CYC_W-1:0] long_len_i,
  output logic             pwm_o,
  output logic             cycle_end_o
);

  logic             run_q;
  logic             adv;
  logic             tick;
  logic             wrap;
  logic             long_end;
  logic             load_cfg;

  div_sel_e         sel_q,    sel_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] duty_q,   duty_d;
  logic [CYC_W-1:0] burst_q,  burst_d;
  logic [CYC_W-1:0] long_q,   long_d;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CYC_W-1:0] cyc_q, cyc_nxt;
  logic             pwm_q, pwm_d;
  logic             ce_q;

  assign adv      = run_q && en_i;
  assign load_cfg = !run_q || long_end;

  // shadow configuration
  always_comb begin
    sel_d    = load_cfg ? div_sel_e'(div_sel_i) : sel_q;
    period_d = load_cfg ? period_i    : period_q;
    duty_d   = load_cfg ? duty_i      : duty_q;
    burst_d  = load_cfg ? burst_len_i : burst_q;
    long_d   = load_cfg ? long_len_i  : long_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= DIV_1;
      period_q <= '0;
      duty_q   <= '0;
      burst_q  <= '0;
      long_q   <= '0;
    end else begin
      sel_q    <= sel_d;
      period_q <= period_d;
      duty_q   <= duty_d;
      burst_q  <= burst_d;
      long_q   <= long_d;
    end
  end

  burst_pwm_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .clr_i  (long_end),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  burst_pwm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .tick_i    (tick),
    .period_i  (period_q),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  burst_pwm_cycler #(.CYC_W(CYC_W)) u_cycler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .wrap_i     (wrap),
    .long_len_i (long_q),
    .cyc_o      (cyc_q),
    .cyc_nxt_o  (cyc_nxt),
    .long_end_o (long_end)
  );

  // output registered against next state; burst gate only moves at wrap (count 0)
  assign pwm_d = en_i && (cyc_nxt < burst_d) && (cnt_nxt < duty_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pwm_q <= 1'b0;
      ce_q  <= 1'b0;
    end else begin
      run_q <= en_i;
      pwm_q <= pwm_d;
      ce_q  <= wrap;
    end
  end

  assign pwm_o       = pwm_q;
  assign cycle_end_o = ce_q;

endmodule

// File: rtl/burst_pwm_gen_chk.sv
module burst_pwm_gen_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CYC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pwm_o,
  input logic             cycle_end_o,
  input logic             run_q,
  input logic             long_end,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] period_q,
  input logic [CNT_W-1:0] duty_q,
  input logic [CYC_W-1:0] cyc_q,
  input logic [CYC_W-1:0] burst_q,
  input logic [CYC_W-1:0] long_q
);

  a_r6_disable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);

  a_r6_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (cnt_q == '0) && (cyc_q == '0) && !cycle_end_o);

  a_r3_rest_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && (cyc_q >= burst_q) |-> !pwm_o);

  a_r3_cyc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && (long_q != '0) |-> cyc_q < long_q);

  a_r2_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && (duty_q == '0) |-> !pwm_o);

  a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q <= period_q);

  a_r5_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && en_i && !long_end |=>
      $stable(period_q) && $stable(duty_q) && $stable(burst_q) && $stable(long_q));

  a_r7_strobe_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_o |-> cnt_q == '0);

endmodule

bind burst_pwm_gen burst_pwm_gen_chk #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .pwm_o       (pwm_o),
  .cycle_end_o (cycle_end_o),
  .run_q       (run_q),
  .long_end    (long_end),
  .cnt_q       (cnt_q),
  .period_q    (period_q),
  .duty_q      (duty_q),
  .cyc_q       (cyc_q),
  .burst_q     (burst_q),
  .long_q      (long_q)
);

// File: tb/burst_pwm_gen_tb.sv
module burst_pwm_gen_tb;

  localparam int CNT_W = 16;
  localparam int CYC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [1:0]       div_sel = '0;
  logic [CNT_W-1:0] period = '0;
  logic [CNT_W-1:0] duty = '0;
  logic [CYC_W-1:0] burst_len = '0;
  logic [CYC_W-1:0] long_len = '0;
  logic             pwm;
  logic             cycle_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_pwm_gen #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .div_sel_i   (div_sel),
    .period_i    (period),
    .duty_i      (duty),
    .burst_len_i (burst_len),
    .long_len_i  (long_len),
    .pwm_o       (pwm),
    .cycle_end_o (cycle_end)
  );

  typedef struct {
    int sel;
    int per;
    int dty;
    int n;
    int l;
  } cfg_t;

  function automatic bit exp_pwm(cfg_t c, int t);
    int tl, slot, p, l, cyc, pos;
    tl   = 1 << c.sel;
    slot = t / tl;
    p    = c.per + 1;
    l    = (c.l < 1) ? 1 : c.l;
    cyc  = (slot / p) % l;
    pos  = slot % p;
    return (cyc < c.n) && (pos < c.dty);
  endfunction

  function automatic bit exp_ce(cfg_t c, int t);
    int tl;
    tl = 1 << c.sel;
    return (t > 0) && (t % tl == 0) && ((t / tl) % (c.per + 1) == 0);
  endfunction

  function automatic int frame_clks(cfg_t c);
    return ((c.l < 1) ? 1 : c.l) * (c.per + 1) * (1 << c.sel);
  endfunction

  task automatic apply_cfg(cfg_t c);
    div_sel   = 2'(c.sel);
    period    = CNT_W'(c.per);
    duty      = CNT_W'(c.dty);
    burst_len = CYC_W'(c.n);
    long_len  = CYC_W'(c.l);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // enable with cfg a; after switch_at clocks present cfg b (if switch_at >= 0)
  task automatic run_wave(cfg_t a, cfg_t b, int switch_at, int clks, string req);
    int bad_p, bad_c, ta;
    int bt, ba, be, ct, ca, ce;
    bit ep, ec;
    bad_p = 0; bad_c = 0;
    bt = -1; ba = 0; be = 0; ct = -1; ca = 0; ce = 0;
    ta = frame_clks(a);
    @(negedge clk);
    en = 1'b0;
    apply_cfg(a);
    @(negedge clk);
    en = 1'b1;
    for (int t = 0; t < clks; t++) begin
      @(negedge clk);
      if (switch_at >= 0 && t == switch_at) apply_cfg(b);
      if (switch_at < 0 || t < ta) begin
        ep = exp_pwm(a, t);
        ec = exp_ce(a, t);
      end else begin
        ep = exp_pwm(b, t - ta);
        ec = (t == ta) || exp_ce(b, t - ta);
      end
      if (pwm !== ep) begin
        if (bt < 0) begin bt = t; ba = int'(pwm); be = int'(ep); end
        bad_p++;
      end
      if (cycle_end !== ec) begin
        if (ct < 0) begin ct = t; ca = int'(cycle_end); ce = int'(ec); end
        bad_c++;
      end
    end
    check(bad_p == 0, req, $sformatf("pwm_o at clock %0d", bt), ba, be);
    check(bad_c == 0, "R7", $sformatf("cycle_end_o at clock %0d", ct), ca, ce);
  endtask

  task automatic test_reset();
    #5;
    check(pwm == 1'b0, "R8", "pwm_o in reset", int'(pwm), 0);
    check(cycle_end == 1'b0, "R8", "cycle_end_o in reset", int'(cycle_end), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm == 1'b0, "R8", "pwm_o after reset idle", int'(pwm), 0);
  endtask

  task automatic test_basic();
    cfg_t c = '{sel: 0, per: 9, dty: 4, n: 2, l: 5};
    run_wave(c, c, -1, 2 * frame_clks(c) + 7, "R1 R2 R3 basic");
    c = '{sel: 0, per: 3, dty: 2, n: 3, l: 4};
    run_wave(c, c, -1, 40, "R1 R3 short period");
  endtask

  task automatic test_prescale();
    cfg_t c;
    c = '{sel: 1, per: 4, dty: 2, n: 1, l: 3};
    run_wave(c, c, -1, 2 * frame_clks(c), "R4 div2");
    c = '{sel: 2, per: 3, dty: 1, n: 1, l: 3};
    run_wave(c, c, -1, 2 * frame_clks(c), "R4 div4");
    c = '{sel: 3, per: 4, dty: 3, n: 2, l: 3};
    run_wave(c, c, -1, 2 * frame_clks(c), "R4 div8");
  endtask

  task automatic test_duty_edges();
    cfg_t c;
    c = '{sel: 0, per: 7, dty: 0, n: 2, l: 3};
    run_wave(c, c, -1, 60, "R2 duty zero");
    c = '{sel: 0, per: 7, dty: 8, n: 2, l: 3};
    run_wave(c, c, -1, 60, "R2 duty period+1");
    c = '{sel: 0, per: 7, dty: 300, n: 1, l: 4};
    run_wave(c, c, -1, 70, "R2 duty large");
  endtask

  task automatic test_gate_edges();
    cfg_t c;
    c = '{sel: 0, per: 5, dty: 2, n: 0, l: 4};
    run_wave(c, c, -1, 60, "R3 burst zero");
    c = '{sel: 0, per: 5, dty: 2, n: 3, l: 0};
    run_wave(c, c, -1, 40, "R3 long zero");
    c = '{sel: 0, per: 5, dty: 3, n: 6, l: 4};
    run_wave(c, c, -1, 60, "R3 burst above long");
  endtask

  task automatic test_midframe_change();
    cfg_t a = '{sel: 0, per: 6, dty: 3, n: 2, l: 3};
    cfg_t b = '{sel: 1, per: 4, dty: 2, n: 1, l: 2};
    run_wave(a, b, 3, frame_clks(a) + 2 * frame_clks(b), "R5 midframe change");
  endtask

  task automatic test_disable();
    cfg_t c = '{sel: 0, per: 9, dty: 6, n: 3, l: 4};
    int hi_seen;
    @(negedge clk);
    en = 1'b0;
    apply_cfg(c);
    @(negedge clk);
    en = 1'b1;
    for (int t = 0; t < 13; t++) @(negedge clk);
    check(pwm == 1'b1, "R6", "pwm_o high before disable", int'(pwm), 1);
    en = 1'b0;
    @(negedge clk);
    check(pwm == 1'b0, "R6", "pwm_o one clock after disable", int'(pwm), 0);
    hi_seen = 0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (pwm || cycle_end) hi_seen++;
    end
    check(hi_seen == 0, "R6", "outputs active while disabled", hi_seen, 0);
    run_wave(c, c, -1, 2 * frame_clks(c), "R6 restart");
  endtask

  initial begin
    test_reset();
    test_basic();
    test_prescale();
    test_duty_edges();
    test_gate_edges();
    test_midframe_change();
    test_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule